// File: doc/BRIEF.md
# Synthesizer Configuration Register Bank with SPI Access

This block is the serial configuration front end of a frequency synthesizer. An external controller reaches four 8-bit configuration registers through a four-wire SPI slave port. The registers hold the feedback divider, the reference divider and a control byte. The SPI pins are asynchronous to the system clock. They pass through synchronisers, and all framing, storage and output logic runs in the system clock domain. The system clock must run at least eight times faster than SCK, so that each SCK level lasts at least four system clocks.

A frame starts when chip-select falls. The bytes that follow alternate between an address byte and a data byte, so one frame may carry any number of address/data pairs. Writes do not change the active configuration at once. They are collected in a staging copy, and the whole set becomes active in a single system clock when chip-select rises. At that commit point the block emits a one-cycle calibration request if the frame wrote a register that requires the oscillator to be retuned. A sleep input makes the port inert and discards any staged writes.

Top module: `cfg_spi_regbank`

## Requirements
- R1: After reset, fb_div, ref_div, squelch_off, cal_on_ref and drive_code are all zero, and spi_miso_oe and cal_kick are low.
- R2: Each byte is shifted MSB first, with MOSI sampled on the SCK rising edge. Within one low period of spi_csn, bytes alternate between address and data, starting with an address. In an address byte, bit 7 = 1 means write and bit 7 = 0 means read, and bits 6:0 give the register number.
- R3: Written values are not visible on the outputs before spi_csn rises. All pairs written in one frame become visible together at that rise.
- R4: Register 0 drives fb_div[7:0]. Register 1 bits 1:0 drive fb_div[9:8]. Register 2 bits 5:0 drive ref_div. Register 3 has bit 3 = squelch_off, bit 2 = cal_on_ref and bits 1:0 = drive_code. Bits outside these fields are stored as 0 and read back as 0.
- R5: During the data byte of a read, spi_miso shifts out the committed register value MSB first. Each bit changes on an SCK falling edge, and the first bit appears after the falling edge that follows the last address bit.
- R6: spi_miso is 0 during address bytes and during the data byte of a write.
- R7: After a commit, cal_kick pulses for exactly one system clock if the frame wrote register 0, or wrote register 2 while the cal_on_ref value being committed is 1. Otherwise it does not pulse. A commit produces at most one pulse.
- R8: Addresses whose bits 6:2 are not all zero are unmapped. Writes to them change nothing, and reads from them return 0.
- R9: A byte left incomplete when spi_csn rises has no effect.
- R10: spi_miso_oe is high only while spi_csn is low and sleep_n is high. While sleep_n is low, SPI traffic is ignored and any staged writes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI data in |
| spi_miso | output | 1 | SPI data out |
| spi_miso_oe | output | 1 | Output enable for the MISO pad |
| sleep_n | input | 1 | Low puts the port to sleep |
| fb_div | output | FB_DIV_W | Active feedback divider value |
| ref_div | output | REF_DIV_W | Active reference divider value |
| squelch_off | output | 1 | Output stays enabled regardless of lock |
| cal_on_ref | output | 1 | Reference divider writes also request calibration |
| drive_code | output | 2 | Output buffer current code |
| cal_kick | output | 1 | One-cycle calibration request |

## Verification
The hardest case to reach is a frame that changes the calibration mode and writes the reference divider in the same burst. The request must then follow the mode value being committed, not the previously active one. The bench builds that case from two frames. The first sets the mode, and a reference divider write after it must pulse. The second clears the mode and writes the reference divider in one burst, and must not pulse. A sleep assertion in the middle of a frame that has already staged a write is also covered, with the commit performed after sleep is released.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

   localparam int unsigned NUM_REGS  = 4;
   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned IDX_W     = $clog2(NUM_REGS);
   localparam int unsigned CTRL_SQ   = 3;
   localparam int unsigned CTRL_CAL  = 2;

   typedef enum logic [IDX_W-1:0] {
      REG_FB_LO = 2'd0,
      REG_FB_HI = 2'd1,
      REG_REF   = 2'd2,
      REG_CTRL  = 2'd3
   } reg_idx_e;

   typedef struct packed {
      logic     is_wr;
      logic     mapped;
      reg_idx_e idx;
   } access_t;

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_spi_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/cfg_spi_framer.sv
module cfg_spi_framer
   import cfg_spi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_s,
   input  logic              sck_s,
   input  logic              mosi_s,
   input  logic              sleep_s,
   output reg_idx_e          rd_idx,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_stb,
   output reg_idx_e          wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic              commit_stb,
   output logic              discard,
   output logic              miso,
   output logic              miso_oe
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   logic              sck_q, csn_q;
   logic              sck_rise, sck_fall, csn_rise;
   logic              active;
   logic [CNT_W-1:0]  bit_cnt;
   logic              data_ph;
   logic [BYTE_W-2:0] shreg;
   logic [BYTE_W-1:0] byte_next;
   logic [BYTE_W-1:0] rd_shift;
   access_t           acc, acc_next;
   logic              byte_done;

   assign sck_rise  = sck_s & ~sck_q;
   assign sck_fall  = ~sck_s & sck_q;
   assign csn_rise  = csn_s & ~csn_q;
   assign active    = ~csn_s & sleep_s;
   assign byte_next = {shreg, mosi_s};
   assign byte_done = active & sck_rise & (bit_cnt == LAST_BIT);

   always_comb begin
      acc_next.is_wr  = byte_next[BYTE_W-1];
      acc_next.mapped = (byte_next[BYTE_W-2:IDX_W] == '0);
      acc_next.idx    = reg_idx_e'(byte_next[IDX_W-1:0]);
   end

   assign rd_idx = acc_next.idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         csn_q <= 1'b1;
      end else begin
         sck_q <= sck_s;
         csn_q <= csn_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         data_ph  <= 1'b0;
         shreg    <= '0;
         rd_shift <= '0;
         miso     <= 1'b0;
         acc      <= '0;
      end else if (!active) begin
         bit_cnt  <= '0;
         data_ph  <= 1'b0;
         rd_shift <= '0;
         miso     <= 1'b0;
      end else if (sck_rise) begin
         shreg   <= byte_next[BYTE_W-2:0];
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == LAST_BIT) begin
            data_ph <= ~data_ph;
            if (!data_ph) begin
               acc      <= acc_next;
               rd_shift <= (!acc_next.is_wr && acc_next.mapped) ? rd_data : '0;
            end
         end
      end else if (sck_fall) begin
         miso     <= rd_shift[BYTE_W-1];
         rd_shift <= {rd_shift[BYTE_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_stb     <= 1'b0;
         wr_idx     <= REG_FB_LO;
         wr_data    <= '0;
         commit_stb <= 1'b0;
         miso_oe    <= 1'b0;
      end else begin
         wr_stb     <= byte_done & data_ph & acc.is_wr & acc.mapped;
         if (byte_done & data_ph) begin
            wr_idx  <= acc.idx;
            wr_data <= byte_next;
         end
         commit_stb <= csn_rise & sleep_s;
         miso_oe    <= active;
      end
   end

   assign discard = ~sleep_s;

endmodule

// File: rtl/cfg_spi_regfile.sv
module cfg_spi_regfile
   import cfg_spi_pkg::*;
#(
   parameter int unsigned FB_DIV_W  = 10,
   parameter int unsigned REF_DIV_W = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_stb,
   input  reg_idx_e             wr_idx,
   input  logic [BYTE_W-1:0]    wr_data,
   input  logic                 commit_stb,
   input  logic                 discard,
   input  reg_idx_e             rd_idx,
   output logic [BYTE_W-1:0]    rd_data,
   output logic [FB_DIV_W-1:0]  fb_div,
   output logic [REF_DIV_W-1:0] ref_div,
   output logic [3:0]           ctrl,
   output logic                 cal_kick
);

   localparam int unsigned FB_HI_W = FB_DIV_W - BYTE_W;

   function automatic logic [BYTE_W-1:0] field_mask(input int unsigned r);
      logic [BYTE_W-1:0] m;
      case (r)
         0:       m = '1;
         1:       m = BYTE_W'((1 << FB_HI_W) - 1);
         2:       m = BYTE_W'((1 << REF_DIV_W) - 1);
         default: m = BYTE_W'(4'hF);
      endcase
      return m;
   endfunction

   logic [BYTE_W-1:0] shadow [NUM_REGS];
   logic [BYTE_W-1:0] live   [NUM_REGS];
   logic              pend_lo, pend_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            shadow[r] <= '0;
            live[r]   <= '0;
         end
      end else if (discard) begin
         for (int r = 0; r < NUM_REGS; r++) shadow[r] <= live[r];
      end else if (commit_stb) begin
         for (int r = 0; r < NUM_REGS; r++) live[r] <= shadow[r];
      end else if (wr_stb) begin
         for (int r = 0; r < NUM_REGS; r++)
            if (wr_idx == reg_idx_e'(r)) shadow[r] <= wr_data & field_mask(r);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_lo  <= 1'b0;
         pend_ref <= 1'b0;
         cal_kick <= 1'b0;
      end else begin
         cal_kick <= commit_stb & ~discard &
                     (pend_lo | (pend_ref & shadow[REG_CTRL][CTRL_CAL]));
         if (discard || commit_stb) begin
            pend_lo  <= 1'b0;
            pend_ref <= 1'b0;
         end else if (wr_stb) begin
            if (wr_idx == REG_FB_LO) pend_lo  <= 1'b1;
            if (wr_idx == REG_REF)   pend_ref <= 1'b1;
         end
      end
   end

   assign rd_data = live[rd_idx];
   assign fb_div  = {live[REG_FB_HI][FB_HI_W-1:0], live[REG_FB_LO]};
   assign ref_div = live[REG_REF][REF_DIV_W-1:0];
   assign ctrl    = live[REG_CTRL][3:0];

endmodule

// File: rtl/cfg_spi_regbank.sv
module cfg_spi_regbank
   import cfg_spi_pkg::*;
#(
   parameter int unsigned FB_DIV_W    = 10,
   parameter int unsigned REF_DIV_W   = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 sys_clk,
   input  logic                 sys_rst_n,
   input  logic                 spi_csn,
   input  logic                 spi_sck,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic                 spi_miso_oe,
   input  logic                 sleep_n,
   output logic [FB_DIV_W-1:0]  fb_div,
   output logic [REF_DIV_W-1:0] ref_div,
   output logic                 squelch_off,
   output logic                 cal_on_ref,
   output logic [1:0]           drive_code,
   output logic                 cal_kick
);

   generate
      if (FB_DIV_W <= BYTE_W || FB_DIV_W > 2 * BYTE_W) begin : g_bad_fb
         $error("cfg_spi_regbank: FB_DIV_W must be 9..16");
      end
      if (REF_DIV_W < 1 || REF_DIV_W > BYTE_W) begin : g_bad_ref
         $error("cfg_spi_regbank: REF_DIV_W must be 1..8");
      end
   endgenerate

   logic              csn_s, sck_s, mosi_s, sleep_s;
   logic [3:0]        pins_s;
   reg_idx_e          rd_idx, wr_idx;
   logic [BYTE_W-1:0] rd_data, wr_data;
   logic              wr_stb, commit_stb, discard;
   logic [3:0]        ctrl;

   cfg_spi_sync #(
      .WIDTH  (4),
      .STAGES (SYNC_STAGES),
      .RST_VAL(4'b1000)
   ) i_sync (
      .clk  (sys_clk),
      .rst_n(sys_rst_n),
      .d    ({spi_csn, spi_sck, spi_mosi, sleep_n}),
      .q    (pins_s)
   );

   assign {csn_s, sck_s, mosi_s, sleep_s} = pins_s;

   cfg_spi_framer i_framer (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .csn_s     (csn_s),
      .sck_s     (sck_s),
      .mosi_s    (mosi_s),
      .sleep_s   (sleep_s),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .commit_stb(commit_stb),
      .discard   (discard),
      .miso      (spi_miso),
      .miso_oe   (spi_miso_oe)
   );

   cfg_spi_regfile #(
      .FB_DIV_W (FB_DIV_W),
      .REF_DIV_W(REF_DIV_W)
   ) i_regfile (
      .clk       (sys_clk),
      .rst_n     (sys_rst_n),
      .wr_stb    (wr_stb),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .commit_stb(commit_stb),
      .discard   (discard),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .fb_div    (fb_div),
      .ref_div   (ref_div),
      .ctrl      (ctrl),
      .cal_kick  (cal_kick)
   );

   assign squelch_off = ctrl[CTRL_SQ];
   assign cal_on_ref  = ctrl[CTRL_CAL];
   assign drive_code  = ctrl[1:0];

endmodule

// File: rtl/cfg_spi_regbank_chk.sv
module cfg_spi_regbank_chk #(
   parameter int unsigned FB_DIV_W  = 10,
   parameter int unsigned REF_DIV_W = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cal_kick,
   input logic                 commit_stb,
   input logic                 sleep_s,
   input logic                 miso_oe,
   input logic [FB_DIV_W-1:0]  fb_div,
   input logic [REF_DIV_W-1:0] ref_div
);

   // R7
   cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_kick |=> !cal_kick);

   // R7
   cal_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cal_kick |-> $past(commit_stb));

   // R3
   fb_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fb_div) |-> $past(commit_stb));

   // R3
   ref_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_div) |-> $past(commit_stb));

   // R10
   sleep_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_s |=> !miso_oe);

endmodule

bind cfg_spi_regbank cfg_spi_regbank_chk #(
   .FB_DIV_W (FB_DIV_W),
   .REF_DIV_W(REF_DIV_W)
) i_chk (
   .clk       (sys_clk),
   .rst_n     (sys_rst_n),
   .cal_kick  (cal_kick),
   .commit_stb(commit_stb),
   .sleep_s   (sleep_s),
   .miso_oe   (spi_miso_oe),
   .fb_div    (fb_div),
   .ref_div   (ref_div)
);

// File: tb/test_cfg_spi_regbank.sv
module test_cfg_spi_regbank;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       csn = 1'b1, sck = 1'b0, mosi = 1'b0, sleep_n = 1'b1;
   logic       miso, miso_oe;
   logic [9:0] fb_div;
   logic [5:0] ref_div;
   logic       squelch_off, cal_on_ref, cal_kick;
   logic [1:0] drive_code;

   int n_chk = 0, n_fail = 0, cal_cnt = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (cal_kick) cal_cnt++;

   cfg_spi_regbank i_cfg_spi_regbank (
      .sys_clk(clk), .sys_rst_n(rst_n),
      .spi_csn(csn), .spi_sck(sck), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .sleep_n(sleep_n),
      .fb_div(fb_div), .ref_div(ref_div), .squelch_off(squelch_off),
      .cal_on_ref(cal_on_ref), .drive_code(drive_code), .cal_kick(cal_kick)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         mosi = tx[i];
         cyc(HALF);
         rx[i] = miso;
         sck = 1'b1;
         cyc(HALF);
         sck = 1'b0;
      end
   endtask

   task automatic cs_begin();
      csn = 1'b0;
      cyc(HALF);
   endtask

   task automatic cs_end();
      cyc(HALF);
      csn = 1'b1;
      cyc(12);
   endtask

   task automatic wr_pair(input logic [7:0] addr, input logic [7:0] data);
      logic [7:0] rx;
      xfer(addr | 8'h80, rx);
      xfer(data, rx);
   endtask

   task automatic t_reset();
      chk("R1 fb_div", fb_div, 0);
      chk("R1 ref_div", ref_div, 0);
      chk("R1 ctrl", {squelch_off, cal_on_ref, drive_code}, 0);
      chk("R1 oe", miso_oe, 0);
      chk("R1 cal", cal_cnt, 0);
   endtask

   task automatic t_single_write();
      cs_begin(); wr_pair(8'h01, 8'hFF); cs_end();
      chk("R4 fb_hi masked", fb_div, 10'h300);
      chk("R7 no cal on reg1", cal_cnt, 0);
      cs_begin(); wr_pair(8'h00, 8'h5A); cs_end();
      chk("R2 fb write", fb_div, 10'h35A);
      chk("R7 cal on reg0", cal_cnt, 1);
   endtask

   task automatic t_deferred();
      logic [7:0] rx;
      cs_begin();
      xfer(8'h80, rx);
      chk("R6 miso in addr byte", rx, 0);
      xfer(8'h21, rx);
      chk("R6 miso in write data", rx, 0);
      chk("R10 oe in frame", miso_oe, 1);
      wr_pair(8'h02, 8'hFF);
      cyc(20);
      chk("R3 fb not yet", fb_div, 10'h35A);
      chk("R3 ref not yet", ref_div, 0);
      cs_end();
      chk("R3 fb committed", fb_div, 10'h321);
      chk("R4 ref masked", ref_div, 6'h3F);
      chk("R7 one pulse", cal_cnt, 2);
      chk("R10 oe after frame", miso_oe, 0);
   endtask

   task automatic t_read();
      logic [7:0] rx;
      cs_begin();
      xfer(8'h00, rx);
      xfer(8'h00, rx);
      chk("R5 read reg0", rx, 8'h21);
      xfer(8'h02, rx);
      chk("R6 addr byte zero", rx, 0);
      xfer(8'h00, rx);
      chk("R5 burst read reg2", rx, 8'h3F);
      xfer(8'h01, rx);
      xfer(8'h00, rx);
      chk("R4 read reg1", rx, 8'h03);
      cs_end();
   endtask

   task automatic t_cal_mode();
      logic [7:0] rx;
      cs_begin(); wr_pair(8'h02, 8'h05); cs_end();
      chk("R7 reg2 no cal when mode 0", cal_cnt, 2);
      chk("R4 ref", ref_div, 6'h05);
      cs_begin(); wr_pair(8'h03, 8'hFF); cs_end();
      chk("R4 ctrl fields", {squelch_off, cal_on_ref, drive_code}, 4'hF);
      chk("R7 ctrl write no cal", cal_cnt, 2);
      cs_begin(); xfer(8'h03, rx); xfer(8'h00, rx); cs_end();
      chk("R4 ctrl readback", rx, 8'h0F);
      cs_begin(); wr_pair(8'h02, 8'h07); cs_end();
      chk("R7 reg2 cal when mode 1", cal_cnt, 3);
      cs_begin(); wr_pair(8'h03, 8'h00); wr_pair(8'h02, 8'h09); cs_end();
      chk("R7 mode cleared same frame", cal_cnt, 3);
      chk("R3 both committed", {cal_on_ref, ref_div}, {1'b0, 6'h09});
   endtask

   task automatic t_unmapped();
      logic [7:0] rx;
      cs_begin(); wr_pair(8'h04, 8'hFF); wr_pair(8'h7F, 8'hFF); cs_end();
      chk("R8 fb unchanged", fb_div, 10'h321);
      chk("R8 ref unchanged", ref_div, 6'h09);
      chk("R8 ctrl unchanged", {squelch_off, cal_on_ref, drive_code}, 0);
      chk("R8 no cal", cal_cnt, 3);
      cs_begin(); xfer(8'h04, rx); xfer(8'h00, rx); cs_end();
      chk("R8 read zero", rx, 0);
   endtask

   task automatic t_partial();
      logic [7:0] rx;
      cs_begin();
      xfer(8'h80, rx);
      for (int i = 0; i < 4; i++) begin
         mosi = 1'b1;
         cyc(HALF); sck = 1'b1; cyc(HALF); sck = 1'b0;
      end
      cs_end();
      chk("R9 partial byte fb", fb_div, 10'h321);
      chk("R9 partial byte cal", cal_cnt, 3);
   endtask

   task automatic t_sleep();
      cs_begin();
      wr_pair(8'h02, 8'h3F);
      sleep_n = 1'b0;
      cyc(10);
      chk("R10 oe in sleep", miso_oe, 0);
      sleep_n = 1'b1;
      cyc(10);
      cs_end();
      chk("R10 staged discarded", ref_div, 6'h09);
      sleep_n = 1'b0;
      cyc(10);
      cs_begin(); wr_pair(8'h00, 8'h11); cs_end();
      chk("R10 write ignored asleep", fb_div, 10'h321);
      chk("R10 no cal asleep", cal_cnt, 3);
      sleep_n = 1'b1;
      cyc(10);
   endtask

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(5);
      t_reset();
      t_single_write();
      t_deferred();
      t_read();
      t_cal_mode();
      t_unmapped();
      t_partial();
      t_sleep();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule